// File: doc/BRIEF.md
# Five-Level Overlapping-Carrier PWM Modulator

This block turns a stream of signed reference samples into gate enables for a single-phase, five-level cascaded bridge built from six switches. Four triangular carriers run side by side. Each one comes from its own up/down counter, and each is driven in phase opposition to its neighbour. Every clock the held reference is compared against all four carriers at once. The positive-plane carriers that the reference is above add one each. The negative-plane carriers that lie above the reference take away one each. The signed sum is a level from -2 to +2, and a fixed table turns that level into six switch enables.

The carriers can be placed in two ways. In the non-crossing arrangement, the two upper carriers stay at or above zero and the two lower ones stay at or below zero. In the conventional arrangement, the same four carriers are spaced evenly and overlap, so the two middle ones cross zero. The arrangement is chosen by an input pin, and a new choice is applied only when the carriers return to their starting point. The reference arrives on a valid/ready port. The block applies no back-pressure: ready is low only while reset is asserted. The block has no dead-time insertion, and gate timing beyond the level encoding is left to the power stage.

Top module: `apod_pwm_mod`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are `sw_en` = 6'b111000 and `level` = 0. `ref_ready` is low while `rst` is high. The `mode_sel` value seen during reset becomes the initial arrangement.
- R2: `sw_en[5]` drives switch 1 and `sw_en[0]` drives switch 6. The codes are: +2 gives 010101, +1 gives 011100, 0 gives 111000, -1 gives 100011, -2 gives 101010. `level` is a 3-bit two's complement value and always matches `sw_en` through this table.
- R3: Carriers are indexed 0 (bottom) to 3 (top). Carriers 2 and 3 each add +1 when the held reference is strictly greater than them. Carriers 0 and 1 each add -1 when they are strictly greater than the reference. The level is the sum, held to the range -2..+2.
- R4: A carrier step happens once every `STEP_DIV` clocks. Each carrier is an offset plus a count that moves in steps of one between 0 and `CAR_PK`, so one period is 2·`CAR_PK` steps. The counts of even-indexed carriers start at 0 and rise. The counts of odd-indexed carriers start at `CAR_PK` and fall. The counts of neighbouring carriers therefore always add up to `CAR_PK`.
- R5: With `mode_sel`=1 (non-crossing) and Q=`CAR_PK`/4, the carrier offsets for indexes 0..3 are -6Q, -4Q, 0 and 2Q.
- R6: With `mode_sel`=0 (conventional), the carrier offsets for indexes 0..3 are -5Q, -3Q, -Q and Q.
- R7: A change on `mode_sel` is taken up only on the carrier step where the even-indexed counts return to 0. Until then the previous arrangement stays in force.
- R8: A sample is accepted at a clock edge where `ref_valid` and `ref_ready` are both high. If `ref_valid` is low, `ref_sample` is ignored and the last accepted sample stays in use. `ref_ready` is high whenever reset is low.
- R9: The outputs are registered. After a clock edge, `level` and `sw_en` reflect the reference, carriers and arrangement that were held just before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 1 | 1 = non-crossing carriers, 0 = conventional |
| ref_valid | input | 1 | Reference sample valid |
| ref_ready | output | 1 | Reference sample accepted this cycle when high |
| ref_sample | input | REF_W | Signed reference sample |
| sw_en | output | 6 | Switch enables, bit 5 = switch 1 |
| level | output | 3 | Signed output level, -2..+2 |

## Verification
A carrier counter that slips phase or period changes the level pattern seen for a fixed mid-range reference. The bench's timing model catches that within one carrier step, which is `STEP_DIV` clocks. A mode that is latched at the wrong moment shows up as a level that leaves the old arrangement before the period ends, and the directed test watches the exact cycle of the boundary. If a sample taken while valid is low is wrongly captured, the output jumps on the next clock. A wrong encoding entry shows at once as a `sw_en`/`level` pair that does not match.

// File: rtl/apod_pkg.sv
`timescale 1ns/1ps
package apod_pkg;

  localparam int NCAR = 4;

  typedef logic [5:0]        sw_t;
  typedef logic signed [2:0] lvl_t;

  localparam sw_t SW_POS2 = 6'b010101;
  localparam sw_t SW_POS1 = 6'b011100;
  localparam sw_t SW_ZERO = 6'b111000;
  localparam sw_t SW_NEG1 = 6'b100011;
  localparam sw_t SW_NEG2 = 6'b101010;

  function automatic sw_t lvl_to_sw(input lvl_t l);
    sw_t s;
    case (l)
      3'b010:  s = SW_POS2;
      3'b001:  s = SW_POS1;
      3'b111:  s = SW_NEG1;
      3'b110:  s = SW_NEG2;
      default: s = SW_ZERO;
    endcase
    return s;
  endfunction

  // Carrier offset for index k in units of q; nz selects the non-crossing set.
  function automatic int car_offset(input int k, input bit nz, input int q);
    int o;
    if (nz) o = (k < 2) ? (-6 * q + 2 * q * k) : (2 * q * k - 4 * q);
    else    o = -5 * q + 2 * q * k;
    return o;
  endfunction

endpackage

// File: rtl/apod_step_gen.sv
`timescale 1ns/1ps
module apod_step_gen #(
  parameter int STEP_DIV = 10
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int DIV_W = (STEP_DIV > 2) ? $clog2(STEP_DIV) : 1;
  localparam logic [DIV_W-1:0] LAST = DIV_W'(STEP_DIV - 1);

  logic [DIV_W-1:0] div_cnt;

  assign tick = (div_cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst)       div_cnt <= '0;
    else if (tick) div_cnt <= '0;
    else           div_cnt <= div_cnt + 1'b1;
  end
endmodule

// File: rtl/apod_tri_cnt.sv
`timescale 1ns/1ps
module apod_tri_cnt #(
  parameter int CAR_PK    = 2000,
  parameter int CNT_W     = 11,
  parameter bit START_TOP = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] PK_V  = CNT_W'(CAR_PK);
  localparam logic [CNT_W-1:0] PK_M1 = CNT_W'(CAR_PK - 1);
  localparam logic [CNT_W-1:0] ONE_V = CNT_W'(1);

  logic rising;

  // Step that brings the count back to its starting extreme.
  generate
    if (START_TOP) begin : g_top
      assign wrap = tick && rising && (cnt == PK_M1);
    end else begin : g_bot
      assign wrap = tick && !rising && (cnt == ONE_V);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= START_TOP ? PK_V : '0;
      rising <= !START_TOP;
    end else if (tick) begin
      if (rising) begin
        cnt <= cnt + 1'b1;
        if (cnt == PK_M1) rising <= 1'b0;
      end else begin
        cnt <= cnt - 1'b1;
        if (cnt == ONE_V) rising <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/apod_level_det.sv
`timescale 1ns/1ps
module apod_level_det
  import apod_pkg::*;
#(
  parameter int REF_W  = 16,
  parameter int CNT_W  = 11,
  parameter int CAR_PK = 2000
) (
  input  logic signed [REF_W-1:0]      ref_q,
  input  logic [NCAR-1:0][CNT_W-1:0]   t_vec,
  input  logic                         nz_mode,
  output lvl_t                         lvl
);
  localparam int EXT_W = ((REF_W > CNT_W) ? REF_W : CNT_W) + 3;
  localparam int Q     = CAR_PK / 4;

  logic signed [EXT_W-1:0] ref_x;
  logic [NCAR-1:0]         hit;

  assign ref_x = EXT_W'(ref_q);

  generate
    for (genvar k = 0; k < NCAR; k++) begin : g_car
      localparam int OFF_NZ = car_offset(k, 1'b1, Q);
      localparam int OFF_CV = car_offset(k, 1'b0, Q);
      localparam logic signed [EXT_W-1:0] ONZ = EXT_W'(OFF_NZ);
      localparam logic signed [EXT_W-1:0] OCV = EXT_W'(OFF_CV);
      logic signed [EXT_W-1:0] cv;
      assign cv = (nz_mode ? ONZ : OCV)
                + $signed({{(EXT_W-CNT_W){1'b0}}, t_vec[k]});
      if (k >= NCAR / 2) begin : g_pos
        assign hit[k] = (ref_x > cv);
      end else begin : g_neg
        assign hit[k] = (cv > ref_x);
      end
    end
  endgenerate

  logic signed [3:0] acc;

  always_comb begin
    acc = 4'sd0;
    for (int k = 0; k < NCAR; k++) begin
      if (hit[k]) acc = (k >= NCAR / 2) ? acc + 4'sd1 : acc - 4'sd1;
    end
    if (acc > 4'sd2)       lvl = 3'sd2;
    else if (acc < -4'sd2) lvl = -3'sd2;
    else                   lvl = acc[2:0];
  end
endmodule

// File: rtl/apod_pwm_mod.sv
`timescale 1ns/1ps
module apod_pwm_mod
  import apod_pkg::*;
#(
  parameter int REF_W    = 16,
  parameter int CAR_PK   = 2000,
  parameter int STEP_DIV = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    mode_sel,
  input  logic                    ref_valid,
  output logic                    ref_ready,
  input  logic signed [REF_W-1:0] ref_sample,
  output logic [5:0]              sw_en,
  output logic signed [2:0]       level
);
  localparam int CNT_W = $clog2(CAR_PK + 1);

  logic                          tick;
  logic [NCAR-1:0][CNT_W-1:0]    t_vec;
  logic [NCAR-1:0]               wrap_vec;
  logic                          bnd;
  logic                          mode_q;
  logic signed [REF_W-1:0]       ref_q;
  lvl_t                          lvl_d;

  assign ref_ready = ~rst;

  apod_step_gen #(.STEP_DIV(STEP_DIV)) u_step (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  generate
    for (genvar k = 0; k < NCAR; k++) begin : g_cnt
      apod_tri_cnt #(
        .CAR_PK   (CAR_PK),
        .CNT_W    (CNT_W),
        .START_TOP((k % 2) == 1)
      ) u_car (
        .clk (clk),
        .rst (rst),
        .tick(tick),
        .cnt (t_vec[k]),
        .wrap(wrap_vec[k])
      );
    end
  endgenerate

  // Every carrier is back at its starting extreme on the same step.
  assign bnd = &wrap_vec;

  always_ff @(posedge clk) begin
    if (rst)      mode_q <= mode_sel;
    else if (bnd) mode_q <= mode_sel;
  end

  always_ff @(posedge clk) begin
    if (rst)                  ref_q <= '0;
    else if (ref_valid && ref_ready) ref_q <= ref_sample;
  end

  apod_level_det #(
    .REF_W (REF_W),
    .CNT_W (CNT_W),
    .CAR_PK(CAR_PK)
  ) u_det (
    .ref_q  (ref_q),
    .t_vec  (t_vec),
    .nz_mode(mode_q),
    .lvl    (lvl_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_en <= SW_ZERO;
      level <= '0;
    end else begin
      sw_en <= lvl_to_sw(lvl_d);
      level <= lvl_d;
    end
  end
endmodule

// File: rtl/apod_pwm_mod_chk.sv
`timescale 1ns/1ps
module apod_pwm_mod_chk
  import apod_pkg::*;
#(
  parameter int CAR_PK = 2000,
  parameter int CNT_W  = $clog2(CAR_PK + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              ref_ready,
  input logic [5:0]        sw_en,
  input logic signed [2:0] level,
  input logic              mode_q,
  input logic              bnd,
  input logic [CNT_W-1:0]  t_even,
  input logic [CNT_W-1:0]  t_odd
);
  // R1
  rst_zero_chk: assert property (@(posedge clk) rst |=> (sw_en == SW_ZERO && level == 3'sd0));

  // R1
  ready_low_chk: assert property (@(posedge clk) rst |-> !ref_ready);

  // R2
  code_match_chk: assert property (@(posedge clk) disable iff (rst)
    sw_en == lvl_to_sw(level));

  // R3
  level_range_chk: assert property (@(posedge clk) disable iff (rst)
    (level >= -3'sd2) && (level <= 3'sd2));

  // R4
  phase_opp_chk: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, t_even} + {1'b0, t_odd}) == (CNT_W + 1)'(CAR_PK));

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    t_even <= CNT_W'(CAR_PK));

  // R7
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(mode_q) && !$past(rst)) |-> $past(bnd));
endmodule

bind apod_pwm_mod apod_pwm_mod_chk #(.CAR_PK(CAR_PK)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ref_ready(ref_ready),
  .sw_en    (sw_en),
  .level    (level),
  .mode_q   (mode_q),
  .bnd      (bnd),
  .t_even   (t_vec[0]),
  .t_odd    (t_vec[1])
);

// File: tb/apod_pwm_mod_bench.sv
`timescale 1ns/1ps
module apod_pwm_mod_bench;
  localparam int REF_W = 16;
  localparam int PK    = 16;
  localparam int DIV   = 2;
  localparam int Q     = PK / 4;
  localparam int NV    = 12;
  localparam int HOLD  = 72;

  // {mode[27], ref[26:11], hold[10:3], expected level[2:0]}; 3'b100 = model only
  localparam logic [27:0] VEC [NV] = '{
    {1'b1,  16'sd0,  8'd72, 3'b000},
    {1'b1,  16'sd30, 8'd72, 3'b010},
    {1'b1, -16'sd30, 8'd72, 3'b110},
    {1'b1,  16'sd10, 8'd72, 3'b100},
    {1'b1, -16'sd10, 8'd72, 3'b100},
    {1'b1,  16'sd20, 8'd72, 3'b100},
    {1'b1, -16'sd5,  8'd72, 3'b100},
    {1'b0,  16'sd0,  8'd72, 3'b100},
    {1'b0,  16'sd21, 8'd72, 3'b010},
    {1'b0, -16'sd21, 8'd72, 3'b110},
    {1'b0,  16'sd7,  8'd72, 3'b100},
    {1'b0, -16'sd14, 8'd72, 3'b100}
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic                    rst;
  logic                    mode_sel;
  logic                    ref_valid;
  logic                    ref_ready;
  logic signed [REF_W-1:0] ref_sample;
  logic [5:0]              sw_en;
  logic signed [2:0]       level;

  apod_pwm_mod #(.REF_W(REF_W), .CAR_PK(PK), .STEP_DIV(DIV)) u_apod_pwm_mod (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .ref_valid(ref_valid),
    .ref_ready(ref_ready), .ref_sample(ref_sample), .sw_en(sw_en), .level(level)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  function automatic logic [5:0] enc(input int l);
    case (l)
      2:       return 6'b010101;
      1:       return 6'b011100;
      -1:      return 6'b100011;
      -2:      return 6'b101010;
      default: return 6'b111000;
    endcase
  endfunction

  function automatic int mdl_level(input int r, input int ticks, input bit md);
    int nz [4] = '{-6*Q, -4*Q, 0, 2*Q};
    int cv [4] = '{-5*Q, -3*Q, -Q, Q};
    int p, tev, acc;
    p = ticks % (2*PK);
    tev = (p <= PK) ? p : 2*PK - p;
    acc = 0;
    for (int k = 0; k < 4; k++) begin
      int c;
      c = (md ? nz[k] : cv[k]) + (((k % 2) == 0) ? tev : PK - tev);
      if (k >= 2) begin if (r > c) acc++; end
      else begin if (c > r) acc--; end
    end
    return acc;
  endfunction

  // Timing model built from the requirements
  int m_div, m_ticks, m_ref, exp_lvl, ncyc;
  bit m_mode;
  always @(posedge clk) begin
    if (rst) begin
      m_div = 0; m_ticks = 0; m_ref = 0; exp_lvl = 0; ncyc = 0; m_mode = mode_sel;
    end else begin
      exp_lvl = mdl_level(m_ref, m_ticks, m_mode);
      if (ref_valid) m_ref = int'(ref_sample);
      m_div++;
      if (m_div == DIV) begin
        m_div = 0;
        m_ticks++;
        if ((m_ticks % (2*PK)) == 0) m_mode = mode_sel;
      end
      ncyc++;
    end
  end

  task automatic cmp(input string rq, input int e);
    total++;
    if (int'(level) != e || sw_en !== enc(e)) begin
      bad++;
      $display("FAIL %s: level=%0d sw=%b expected level=%0d sw=%b",
               rq, int'(level), sw_en, e, enc(e));
    end
  endtask

  task automatic do_reset(input bit md);
    @(negedge clk);
    rst = 1'b1; mode_sel = md;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    rst = 1'b1; mode_sel = 1'b1; ref_valid = 1'b0; ref_sample = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    total++;
    if (sw_en !== 6'b111000 || level !== 3'sd0 || ref_ready !== 1'b0) begin
      bad++;
      $display("FAIL R1: sw=%b level=%0d ready=%b expected sw=111000 level=0 ready=0",
               sw_en, int'(level), ref_ready);
    end
    rst = 1'b0;
    @(negedge clk);
    // R8 ready high out of reset
    total++;
    if (ref_ready !== 1'b1) begin
      bad++;
      $display("FAIL R8: ready=%b expected 1", ref_ready);
    end

    // Vector walk: R3 R4 R5 R6 R9 against the model, fixed levels where stated
    for (int i = 0; i < NV; i++) begin
      logic [2:0] xf;
      @(negedge clk);
      mode_sel   = VEC[i][27];
      ref_sample = VEC[i][26:11];
      ref_valid  = 1'b1;
      xf = VEC[i][2:0];
      for (int c = 0; c < int'(VEC[i][10:3]); c++) begin
        @(negedge clk);
        cmp("R3 R4 R9 model", exp_lvl);
        if (c >= HOLD - 6 && xf != 3'b100)
          cmp(VEC[i][27] ? "R5 fixed" : "R6 fixed", int'($signed(xf)));
      end
    end

    // R7: mode change mid-period waits for the boundary
    ref_sample = 16'sd21; ref_valid = 1'b1;
    do_reset(1'b0);
    while (ncyc < 10) @(negedge clk);
    mode_sel = 1'b1;
    while (ncyc < 64) begin
      @(negedge clk);
      cmp("R7 old arrangement held", 2);
      cmp("R7 model", exp_lvl);
    end
    @(negedge clk);
    cmp("R7 new arrangement at boundary", 1);

    // R8: sample ignored while valid is low
    ref_sample = 16'sd0;
    repeat (4) @(negedge clk);
    ref_valid = 1'b0; ref_sample = 16'sd30;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      cmp("R8 ignored sample", 0);
    end
    ref_valid = 1'b1;
    repeat (2) @(negedge clk);
    cmp("R8 accepted sample", 2);

    // R1 reset again mid-run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    cmp("R1 reset level", 0);
    rst = 1'b0;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule